// File: doc/BRIEF.md
# Segment-Checked Address Translation Unit

This block turns one memory access per cycle into a physical address, or into one of two faults. The caller presents a linear address that already includes the segment base, together with an access size, write and execute flags, and the attributes, base and limit of the segment the access goes through. Four mode bits choose the path. With protection off the address passes straight through. With protection on and the core not in 64-bit mode, the segment permissions and limit are checked. With paging on, a combinational lookup is sent to an external page-translation cache and its page frame replaces the upper address bits.

The result sits in one registered output stage, held as an enumerated state. `XS_IDLE` means no response this cycle. `XS_XLATE_OK` means a physical address is valid. `XS_GP_FAULT` means a general-protection fault with error code zero. `XS_PAGE_MISS` means a translation-cache miss. Every cycle the state register loads the class of the request presented in that cycle. It goes to `XS_IDLE` when no request is valid, and to one of the other three states by fault priority. Any state can move to any other state in one cycle.

Top module: `seg_xlate_unit`

## Requirements
- R1: With `mode_pe` low, the response is `XS_XLATE_OK`, `rsp_pa` equals the request address, and `lk_req` stays low, whatever the segment attributes, limit or flags are.
- R2: Segment checks are skipped only when `mode_lma` and `cs_long` are both high. In that case no general-protection fault is raised, even if the permissions or the limit would fail.
- R3: With segment checks active, a write (`req_write`=1) to a segment with `seg_writable`=0 gives a general-protection fault.
- R4: With segment checks active, a data read (`req_write`=0 and `req_exec`=0) from a segment with `seg_readable`=0 gives a general-protection fault. A fetch (`req_exec`=1, `req_write`=0) is not subject to the readable check.
- R5: For an expand-up segment (`seg_expdown`=0) whose limit is at or above its base, a fault is raised when limit < address + size. The sum is taken one bit wider than the address.
- R6: For an expand-up segment whose limit is below its base, a fault is raised only when limit < address + size and also address < base.
- R7: For an expand-down segment (`seg_expdown`=1) whose limit is at or above its base, a fault is raised when address <= limit and also address + size >= base.
- R8: For an expand-down segment whose limit is below its base, a fault is raised when address <= limit or when address + size >= base.
- R9: With `mode_pe` and `mode_pg` both high, `lk_req` follows `req_valid`. A miss (`lk_hit`=0) gives a translation-miss fault. A hit gives `rsp_pa` = {`lk_frame`, low PGB bits of the address}.
- R10: With `mode_pe` high and `mode_pg` low, no lookup is made and `rsp_pa` equals the request address when no fault is raised.
- R11: A permission or limit fault takes priority over a translation miss. At most one of `rsp_gp`, `rsp_miss` and `rsp_pa_valid` is high, and exactly one is high when `rsp_valid` is high.
- R12: `rsp_valid` is `req_valid` delayed by one clock. When `rsp_valid` is low, all response flags are low, and reset clears them all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Linear address with segment base applied |
| req_size | input | SW | Access size in bytes |
| req_write | input | 1 | Access is a write |
| req_exec | input | 1 | Access is an instruction fetch |
| seg_writable | input | 1 | Segment allows writes |
| seg_readable | input | 1 | Segment allows data reads |
| seg_expdown | input | 1 | Segment is expand-down |
| seg_base | input | AW | Segment base |
| seg_limit | input | AW | Segment limit |
| mode_pe | input | 1 | Protected mode enabled |
| mode_pg | input | 1 | Paging enabled |
| mode_lma | input | 1 | Long mode active |
| cs_long | input | 1 | Code segment long-mode attribute |
| lk_req | output | 1 | Lookup request to the translation cache |
| lk_vpn | output | AW-PGB | Virtual page number being looked up |
| lk_hit | input | 1 | Translation cache hit |
| lk_frame | input | AW-PGB | Page frame number on a hit |
| rsp_valid | output | 1 | Response present |
| rsp_pa_valid | output | 1 | Physical address is valid |
| rsp_pa | output | AW | Physical address |
| rsp_gp | output | 1 | General-protection fault, error code zero |
| rsp_miss | output | 1 | Translation-miss fault |

## Verification
A segment fault and a translation-cache miss can occur for the same request, because the lookup is issued on every paged request before the segment result is known. The bench provokes this by sweeping every address of a small 8-bit configuration with paging on. Its cache model misses every third page, and the segment limit faults on the upper half of the space, so both conditions occur together on many addresses. The bench judges each response against its own arithmetic model: a general-protection fault must win, only one response flag may be high, and the physical address must not be marked valid.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    typedef enum logic [1:0] {
        XS_IDLE      = 2'd0,
        XS_XLATE_OK  = 2'd1,
        XS_GP_FAULT  = 2'd2,
        XS_PAGE_MISS = 2'd3
    } xlate_state_e;

    typedef struct packed {
        logic writable;
        logic readable;
        logic expdown;
    } seg_attr_t;
endpackage

// File: rtl/xlate_mode_decode.sv
module xlate_mode_decode (
    input  logic mode_pe,
    input  logic mode_pg,
    input  logic mode_lma,
    input  logic cs_long,
    output logic seg_chk_en,
    output logic page_en
);
    logic is_64bit;
    assign is_64bit   = mode_lma & cs_long;
    assign seg_chk_en = mode_pe & ~is_64bit;
    assign page_en    = mode_pe & mode_pg;
endmodule

// File: rtl/seg_perm_check.sv
module seg_perm_check
    import seg_xlate_pkg::*;
(
    input  seg_attr_t attr,
    input  logic      is_write,
    input  logic      is_exec,
    output logic      perm_fault
);
    logic wr_bad;
    logic rd_bad;
    // A fetch is never held to the readable attribute.
    assign wr_bad     = is_write & ~attr.writable;
    assign rd_bad     = ~is_write & ~is_exec & ~attr.readable;
    assign perm_fault = wr_bad | rd_bad;
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check #(
    parameter int AW = 32,
    parameter int SW = 4
) (
    input  logic [AW-1:0] addr,
    input  logic [SW-1:0] size,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    input  logic          expdown,
    output logic          lim_fault
);
    localparam int EW = AW + 1;

    logic [EW-1:0] a_x, b_x, l_x, end_x;
    logic          wrapped;

    assign a_x     = {1'b0, addr};
    assign b_x     = {1'b0, base};
    assign l_x     = {1'b0, limit};
    // One bit wider so a carry out of the address stays visible.
    assign end_x   = a_x + EW'(size);
    assign wrapped = l_x < b_x;

    always_comb begin
        if (!expdown) begin
            if (wrapped) lim_fault = (l_x < end_x) && (a_x < b_x);
            else         lim_fault = (l_x < end_x);
        end else begin
            if (wrapped) lim_fault = (a_x <= l_x) || (end_x >= b_x);
            else         lim_fault = (a_x <= l_x) && (end_x >= b_x);
        end
    end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SW  = 4,
    parameter int PGB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [SW-1:0]     req_size,
    input  logic              req_write,
    input  logic              req_exec,
    input  logic              seg_writable,
    input  logic              seg_readable,
    input  logic              seg_expdown,
    input  logic [AW-1:0]     seg_base,
    input  logic [AW-1:0]     seg_limit,
    input  logic              mode_pe,
    input  logic              mode_pg,
    input  logic              mode_lma,
    input  logic              cs_long,
    output logic              lk_req,
    output logic [AW-PGB-1:0] lk_vpn,
    input  logic              lk_hit,
    input  logic [AW-PGB-1:0] lk_frame,
    output logic              rsp_valid,
    output logic              rsp_pa_valid,
    output logic [AW-1:0]     rsp_pa,
    output logic              rsp_gp,
    output logic              rsp_miss
);
    localparam int FW = AW - PGB;

    xlate_state_e state_q, state_d;
    logic [AW-1:0] pa_q, pa_d;
    logic          seg_chk_en, page_en;
    logic          perm_fault, lim_fault;
    seg_attr_t     attr;

    assign attr = '{writable: seg_writable, readable: seg_readable, expdown: seg_expdown};

    xlate_mode_decode u_mode (
        .mode_pe    (mode_pe),
        .mode_pg    (mode_pg),
        .mode_lma   (mode_lma),
        .cs_long    (cs_long),
        .seg_chk_en (seg_chk_en),
        .page_en    (page_en)
    );

    seg_perm_check u_perm (
        .attr       (attr),
        .is_write   (req_write),
        .is_exec    (req_exec),
        .perm_fault (perm_fault)
    );

    seg_limit_check #(.AW(AW), .SW(SW)) u_limit (
        .addr      (req_addr),
        .size      (req_size),
        .base      (seg_base),
        .limit     (seg_limit),
        .expdown   (seg_expdown),
        .lim_fault (lim_fault)
    );

    assign lk_req = req_valid & page_en;
    assign lk_vpn = req_addr[AW-1:PGB];

    // Next state by priority: permission, limit, then translation miss.
    always_comb begin
        if (!req_valid)                     state_d = XS_IDLE;
        else if (seg_chk_en && perm_fault)  state_d = XS_GP_FAULT;
        else if (seg_chk_en && lim_fault)   state_d = XS_GP_FAULT;
        else if (page_en && !lk_hit)        state_d = XS_PAGE_MISS;
        else                                state_d = XS_XLATE_OK;
    end

    always_comb begin
        if (page_en) pa_d = {lk_frame[FW-1:0], req_addr[PGB-1:0]};
        else         pa_d = req_addr;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
            pa_q    <= '0;
        end else begin
            state_q <= state_d;
            pa_q    <= pa_d;
        end
    end

    // Outputs decoded from state.
    always_comb begin
        rsp_valid    = 1'b0;
        rsp_pa_valid = 1'b0;
        rsp_gp       = 1'b0;
        rsp_miss     = 1'b0;
        rsp_pa       = '0;
        unique case (state_q)
            XS_IDLE: ;
            XS_XLATE_OK: begin
                rsp_valid    = 1'b1;
                rsp_pa_valid = 1'b1;
                rsp_pa       = pa_q;
            end
            XS_GP_FAULT: begin
                rsp_valid = 1'b1;
                rsp_gp    = 1'b1;
            end
            XS_PAGE_MISS: begin
                rsp_valid = 1'b1;
                rsp_miss  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/seg_xlate_unit_chk.sv
module seg_xlate_unit_chk #(
    parameter int AW  = 32,
    parameter int SW  = 4,
    parameter int PGB = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [AW-1:0]     req_addr,
    input logic [SW-1:0]     req_size,
    input logic              req_write,
    input logic              req_exec,
    input logic              seg_writable,
    input logic              seg_readable,
    input logic              seg_expdown,
    input logic [AW-1:0]     seg_base,
    input logic [AW-1:0]     seg_limit,
    input logic              mode_pe,
    input logic              mode_pg,
    input logic              mode_lma,
    input logic              cs_long,
    input logic              lk_req,
    input logic [AW-PGB-1:0] lk_vpn,
    input logic              lk_hit,
    input logic [AW-PGB-1:0] lk_frame,
    input logic              rsp_valid,
    input logic              rsp_pa_valid,
    input logic [AW-1:0]     rsp_pa,
    input logic              rsp_gp,
    input logic              rsp_miss
);
    logic chk_on;
    assign chk_on = mode_pe & ~(mode_lma & cs_long);

    a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r12_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_gp || rsp_miss || rsp_pa_valid));
    a_r11_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_gp, rsp_miss, rsp_pa_valid}) == 1);
    a_r1_real_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mode_pe) |=> (rsp_pa_valid && rsp_pa == $past(req_addr)));
    a_r1_no_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_pe |-> !lk_req);
    a_r2_long_no_gp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_pe && mode_lma && cs_long) |=> !rsp_gp);
    a_r3_write_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_on && req_write && !seg_writable) |=> rsp_gp);
    a_r4_read_nr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_on && !req_write && !req_exec && !seg_readable) |=> rsp_gp);
    a_r9_hit_pa: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_pe && mode_pg && !chk_on && lk_hit) |=>
        (rsp_pa_valid && rsp_pa == {$past(lk_frame), $past(req_addr[PGB-1:0])}));
    a_r9_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_pe && mode_pg && !chk_on && !lk_hit) |=> rsp_miss);
    a_r10_no_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_pe && !mode_pg) |-> !lk_req);
endmodule

bind seg_xlate_unit seg_xlate_unit_chk #(.AW(AW), .SW(SW), .PGB(PGB)) u_chk (.*);

// File: tb/tb_seg_xlate_unit.sv
module tb_seg_xlate_unit;
    localparam int AW  = 8;
    localparam int SW  = 3;
    localparam int PGB = 4;
    localparam int FW  = AW - PGB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [SW-1:0] req_size = 3'd1;
    logic req_write = 1'b0, req_exec = 1'b0;
    logic seg_writable = 1'b1, seg_readable = 1'b1, seg_expdown = 1'b0;
    logic [AW-1:0] seg_base = '0, seg_limit = '1;
    logic mode_pe = 1'b0, mode_pg = 1'b0, mode_lma = 1'b0, cs_long = 1'b0;
    logic lk_req;
    logic [FW-1:0] lk_vpn;
    logic lk_hit;
    logic [FW-1:0] lk_frame;
    logic rsp_valid, rsp_pa_valid, rsp_gp, rsp_miss;
    logic [AW-1:0] rsp_pa;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // Cache model: every third page misses, frame is page XOR 5.
    assign lk_hit   = (int'(lk_vpn) % 3) != 0;
    assign lk_frame = lk_vpn ^ 4'h5;

    seg_xlate_unit #(.AW(AW), .SW(SW), .PGB(PGB)) dut (.*);

    function automatic bit lim_model(int a, int s, int b, int l, bit dn);
        int e = a + s;
        if (!dn) return (l < b) ? (l < e && a < b) : (l < e);
        return (l < b) ? (a <= l || e >= b) : (a <= l && e >= b);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Class encoding: 0 ok, 1 gp, 2 miss, 3 no/invalid response.
    task automatic run_req(string tag, int a, int s, bit w, bit x);
        int cls, pa, vpn, acls;
        bit chk, pgon, gp;
        @(negedge clk);
        req_valid = 1'b1; req_addr = AW'(a); req_size = SW'(s);
        req_write = w; req_exec = x;
        chk  = mode_pe && !(mode_lma && cs_long);
        pgon = mode_pe && mode_pg;
        gp   = chk && ((w && !seg_writable) || (!w && !x && !seg_readable) ||
                       lim_model(a, s, seg_base, seg_limit, seg_expdown));
        vpn  = a / 16;
        if (gp) cls = 1;
        else if (pgon && (vpn % 3) == 0) cls = 2;
        else cls = 0;
        pa = pgon ? (((vpn ^ 5) * 16) + (a % 16)) : a;
        #1;
        if (!pgon && lk_req) check({tag, " lookup"}, 1, 0);
        @(negedge clk);
        acls = !rsp_valid ? 3 : rsp_gp ? 1 : rsp_miss ? 2 : rsp_pa_valid ? 0 : 3;
        if ($countones({rsp_gp, rsp_miss, rsp_pa_valid}) > 1) acls = 4;
        check(tag, acls, cls);
        if (cls == 0) check({tag, " pa"}, int'(rsp_pa), pa);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset valid", int'(rsp_valid), 0);
        check("R12 reset flags", int'({rsp_gp, rsp_miss, rsp_pa_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 idle", int'(rsp_valid), 0);

        // R1: real mode ignores attributes, limit and flags.
        seg_writable = 1'b0; seg_readable = 1'b0; seg_limit = '0; seg_base = 8'h80;
        mode_pg = 1'b1;
        for (int a = 0; a < 256; a += 7) run_req("R1 real", a, 4, 1'b1, 1'b0);

        // R5-R8 and R10: limit sweep, protected mode, paging off.
        mode_pe = 1'b1; mode_pg = 1'b0;
        seg_writable = 1'b1; seg_readable = 1'b1;
        for (int dn = 0; dn < 2; dn++)
            for (int bi = 0; bi < 8; bi++)
                for (int li = 0; li < 8; li++) begin
                    int pts[8] = '{0, 3, 64, 127, 128, 192, 253, 255};
                    string tg;
                    seg_expdown = dn[0]; seg_base = AW'(pts[bi]); seg_limit = AW'(pts[li]);
                    if (dn == 0) tg = (pts[li] < pts[bi]) ? "R6 up wrap" : "R5 up";
                    else         tg = (pts[li] < pts[bi]) ? "R8 down wrap" : "R7 down";
                    for (int a = 0; a < 256; a += 3)
                        for (int s = 1; s <= 4; s *= 2)
                            run_req({tg, " R10"}, a, s, 1'b0, 1'b0);
                end

        // R3, R4: permission sweep with a limit that never faults.
        seg_expdown = 1'b0; seg_base = '0; seg_limit = '1;
        for (int p = 0; p < 16; p++) begin
            seg_writable = p[0]; seg_readable = p[1];
            run_req(p[2] ? "R3 write perm" : "R4 read/fetch perm", 16, 1, p[2], p[3]);
        end

        // R2: only long mode plus long code segment bypasses checks.
        seg_writable = 1'b0; seg_readable = 1'b0; seg_limit = 8'h10;
        for (int m = 0; m < 4; m++) begin
            mode_lma = m[0]; cs_long = m[1];
            run_req("R2 long bypass", 200, 2, 1'b1, 1'b0);
            run_req("R2 long bypass", 100, 1, 1'b0, 1'b0);
        end

        // R9, R11: paging on, limit faults on upper half, every third page misses.
        mode_lma = 1'b0; cs_long = 1'b0; mode_pg = 1'b1;
        seg_writable = 1'b1; seg_readable = 1'b1; seg_base = '0; seg_limit = 8'h7f;
        for (int a = 0; a < 256; a++) run_req("R9 R11 paged", a, 1, 1'b0, 1'b0);
        mode_lma = 1'b1; cs_long = 1'b1;
        for (int a = 0; a < 256; a += 5) run_req("R9 paged long", a, 2, 1'b0, 1'b1);

        // R12: drop the request and see the response go idle.
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check("R12 drop valid", int'(rsp_valid), 0);
        check("R12 drop flags", int'({rsp_gp, rsp_miss, rsp_pa_valid}), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule